// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block merges the event pulses of a flash controller into one level-sensitive interrupt line. Three event sources each set a sticky bit in a cause status register: command completion, a failed slave DMA transfer, and a slave DMA data request. A second sticky register collects per-transaction completion pulses. Software reads a status register, handles what it finds, and writes the same value back. Each 1 in that write clears the matching bit.

Each cause has an enable bit, and one global enable gates all three. The completion register is not masked: any pending completion bit holds the interrupt high. Status bits latch whether or not their cause is enabled. The register file sits on a plain single-cycle read/write bus. Writes take effect at the clock edge, and read data is a combinational decode of the address.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, all three registers read 0 and `irq_o` is low.
- R2: A one-cycle pulse on `ev_cmd_done`, `ev_dma_err` or `ev_dma_req` sets bit 23, 22 or 21 of the cause status register (offset 0x110). The bit stays set after the pulse ends.
- R3: A bus write to 0x110 clears exactly those of bits 23..21 whose data bit is 1. Bits written as 0 keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set afterwards.
- R5: The enable register (offset 0x114) stores bit 31 (global enable) and bits 23..21 (per-cause enables, same positions as the status bits). All other bits read back as 0.
- R6: With no completion bit pending, `irq_o` is high exactly when bit 31 of the enable register is 1 and at least one of status bits 23..21 is set together with its enable bit.
- R7: Status bits latch while their cause or the global enable is off. Enabling a pending cause raises `irq_o` in the cycle after the enabling write.
- R8: A pulse on bit i of `ev_trd_done` sets bit i of the completion register (offset 0x120). A write to 0x120 clears each bit whose data bit is 1 and leaves the others unchanged.
- R9: Any nonzero completion register holds `irq_o` high, whatever the enable register holds.
- R10: Reads from any other offset return 0. Writes to any other offset change no register.
- R11: A bus write never sets a status or completion bit. Writing 1 to a clear bit leaves it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_we | input | 1 | Write strobe, write takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_cmd_done | input | 1 | Command completion event pulse |
| ev_dma_err | input | 1 | Slave DMA error event pulse |
| ev_dma_req | input | 1 | Slave DMA data request event pulse |
| ev_trd_done | input | TRD_W (8) | Per-transaction completion pulses |
| irq_o | output | 1 | Level interrupt request |

## Verification
Every cycle, the assertions check four things:
- a pending bit survives any cycle without a matching clear;
- an event pulse always wins against a clear;
- a write alone never raises a bit;
- a pending completion bit, or an interrupt with no completion pending, is consistent with the global enable.

The bench covers what only scenarios can show:
- the exact readback layout of bits 31 and 23..21, and the zeroing of unimplemented bits and unmapped offsets;
- the interrupt value across all 8 pending-cause patterns against all 16 enable combinations;
- the late-enable case, where a pending cause raises the interrupt once it is enabled.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_W         = 32;
    localparam int N_CAUSE       = 3;
    localparam int CAUSE_LSB     = 21;
    localparam int GLOBAL_EN_BIT = 31;
    localparam int OFS_STATUS    = 'h110;
    localparam int OFS_ENABLE    = 'h114;
    localparam int OFS_TRD       = 'h120;

    // cause index 0 -> bit 21 (dma request), 1 -> bit 22 (dma error), 2 -> bit 23 (cmd done)
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_TRD
    } reg_sel_e;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] pend_o
);
    typedef struct packed {
        logic [W-1:0] pend;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] nxt_bit;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // a set pulse takes priority over a clearing write
        assign nxt_bit[i] = set_i[i] | (st_q.pend[i] & ~(clr_en_i & clr_mask_i[i]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = nxt_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic         glob_wdata_i,
    input  logic [N-1:0] cause_wdata_i,
    output logic         glob_en_o,
    output logic [N-1:0] cause_en_o
);
    typedef struct packed {
        logic         glob;
        logic [N-1:0] cause;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (we_i) begin
            en_d.glob  = glob_wdata_i;
            en_d.cause = cause_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign glob_en_o  = en_q.glob;
    assign cause_en_o = en_q.cause;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [REG_W-1:0]  status_img_i,
    input  logic [REG_W-1:0]  enable_img_i,
    input  logic [REG_W-1:0]  trd_img_i,
    output logic              wr_status_o,
    output logic              wr_enable_o,
    output logic              wr_trd_o,
    output logic [REG_W-1:0]  rdata_o
);
    reg_sel_e sel;

    always_comb begin
        sel = SEL_NONE;
        if      (addr_i == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
        else if (addr_i == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
        else if (addr_i == ADDR_W'(OFS_TRD))    sel = SEL_TRD;
    end

    assign wr_status_o = we_i && (sel == SEL_STATUS);
    assign wr_enable_o = we_i && (sel == SEL_ENABLE);
    assign wr_trd_o    = we_i && (sel == SEL_TRD);

    always_comb begin
        unique case (sel)
            SEL_STATUS: rdata_o = status_img_i;
            SEL_ENABLE: rdata_o = enable_img_i;
            SEL_TRD:    rdata_o = trd_img_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TRD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_cmd_done,
    input  logic              ev_dma_err,
    input  logic              ev_dma_req,
    input  logic [TRD_W-1:0]  ev_trd_done,
    output logic              irq_o
);
    localparam int CAUSE_MSB = CAUSE_LSB + N_CAUSE - 1;

    logic [N_CAUSE-1:0] ev_cause;
    logic [N_CAUSE-1:0] cause_pend;
    logic [N_CAUSE-1:0] cause_en;
    logic [TRD_W-1:0]   trd_pend;
    logic               glob_en;
    logic               wr_status, wr_enable, wr_trd;
    logic [REG_W-1:0]   status_img, enable_img, trd_img;
    logic               unused_wdata_bits;

    assign ev_cause = {ev_cmd_done, ev_dma_err, ev_dma_req};

    irq_reg_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i       (bus_addr),
        .we_i         (bus_we),
        .status_img_i (status_img),
        .enable_img_i (enable_img),
        .trd_img_i    (trd_img),
        .wr_status_o  (wr_status),
        .wr_enable_o  (wr_enable),
        .wr_trd_o     (wr_trd),
        .rdata_o      (bus_rdata)
    );

    irq_w1c_bank #(.W(N_CAUSE)) cause_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ev_cause),
        .clr_en_i   (wr_status),
        .clr_mask_i (bus_wdata[CAUSE_MSB:CAUSE_LSB]),
        .pend_o     (cause_pend)
    );

    irq_w1c_bank #(.W(TRD_W)) trd_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ev_trd_done),
        .clr_en_i   (wr_trd),
        .clr_mask_i (bus_wdata[TRD_W-1:0]),
        .pend_o     (trd_pend)
    );

    irq_enable_reg #(.N(N_CAUSE)) en_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (wr_enable),
        .glob_wdata_i  (bus_wdata[GLOBAL_EN_BIT]),
        .cause_wdata_i (bus_wdata[CAUSE_MSB:CAUSE_LSB]),
        .glob_en_o     (glob_en),
        .cause_en_o    (cause_en)
    );

    always_comb begin
        status_img = '0;
        status_img[CAUSE_MSB:CAUSE_LSB] = cause_pend;
        enable_img = '0;
        enable_img[CAUSE_MSB:CAUSE_LSB] = cause_en;
        enable_img[GLOBAL_EN_BIT]       = glob_en;
        trd_img = '0;
        trd_img[TRD_W-1:0] = trd_pend;
    end

    assign irq_o = (glob_en && |(cause_pend & cause_en)) || (|trd_pend);

    assign unused_wdata_bits = ^bus_wdata;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TRD_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [2:0]        ev_cause,
    input logic [TRD_W-1:0]  ev_trd_done,
    input logic [2:0]        cause_pend,
    input logic [TRD_W-1:0]  trd_pend,
    input logic              glob_en,
    input logic              irq_o
);
    logic [2:0]       c_clr;
    logic [TRD_W-1:0] t_clr;

    assign c_clr = (bus_we && bus_addr == ADDR_W'(OFS_STATUS)) ? bus_wdata[23:21] : 3'b000;
    assign t_clr = (bus_we && bus_addr == ADDR_W'(OFS_TRD)) ? bus_wdata[TRD_W-1:0] : '0;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);

    // R2
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cause_pend) & ~$past(c_clr) & ~cause_pend) == 3'b000));

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ev_cause) & ~cause_pend) == 3'b000));

    // R8
    trd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(ev_trd_done) | ($past(trd_pend) & ~$past(t_clr))) & ~trd_pend) == '0));

    // R11
    no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(cause_pend) & ~$past(ev_cause) & cause_pend) == 3'b000));

    // R9
    trd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trd_pend != '0) |-> irq_o);

    // R6
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && trd_pend == '0) |-> (glob_en && cause_pend != 3'b000));
endmodule

bind irq_agg_top irq_agg_chk #(.ADDR_W(ADDR_W), .TRD_W(TRD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .ev_cause    (ev_cause),
    .ev_trd_done (ev_trd_done),
    .cause_pend  (cause_pend),
    .trd_pend    (trd_pend),
    .glob_en     (glob_en),
    .irq_o       (irq_o)
);

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;
    localparam int ADDR_W = 12;
    localparam int TRD_W  = 8;
    localparam logic [11:0] A_ST = 12'h110, A_EN = 12'h114, A_TRD = 12'h120;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              ev_cmd_done = 1'b0, ev_dma_err = 1'b0, ev_dma_req = 1'b0;
    logic [TRD_W-1:0]  ev_trd_done = '0;
    logic              irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_agg_top #(.ADDR_W(ADDR_W), .TRD_W(TRD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_cmd_done(ev_cmd_done),
        .ev_dma_err(ev_dma_err), .ev_dma_req(ev_dma_req),
        .ev_trd_done(ev_trd_done), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // cause pattern p: bit0 -> dma request (21), bit1 -> dma error (22), bit2 -> cmd done (23)
    task automatic pulse(input logic [2:0] p, input logic [TRD_W-1:0] t);
        @(negedge clk);
        ev_dma_req = p[0]; ev_dma_err = p[1]; ev_cmd_done = p[2]; ev_trd_done = t;
        @(negedge clk);
        ev_dma_req = 1'b0; ev_dma_err = 1'b0; ev_cmd_done = 1'b0; ev_trd_done = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1
        rd(A_ST, v);  chk("R1 status", v, 32'h0);
        rd(A_EN, v);  chk("R1 enable", v, 32'h0);
        rd(A_TRD, v); chk("R1 trd", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 R6: all pending patterns against all enable combinations
        for (int e = 0; e < 16; e++) begin
            logic [31:0] en_clean;
            en_clean = (32'(e >> 3) << 31) | (32'(e & 7) << 21);
            wr(A_EN, en_clean | 32'h0012_3456);
            rd(A_EN, v); chk("R5 enable readback", v, en_clean);
            for (int p = 0; p < 8; p++) begin
                logic exp_irq;
                pulse(3'(p), '0);
                @(negedge clk);
                rd(A_ST, v); chk("R2 sticky status", v, 32'(p) << 21);
                exp_irq = ((e >> 3) != 0) && ((p & e & 7) != 0);
                chk("R6 irq gating", {31'b0, irq_o}, {31'b0, exp_irq});
                wr(A_ST, 32'h00E0_0000);
                rd(A_ST, v); chk("R3 clear all", v, 32'h0);
            end
        end

        // R3: partial clear
        wr(A_EN, 32'h0);
        pulse(3'b111, '0);
        wr(A_ST, 32'h0040_0000);
        rd(A_ST, v); chk("R3 partial clear", v, 32'h00A0_0000);
        // R4: event and clear on same bit, same cycle
        @(negedge clk);
        bus_addr = A_ST; bus_wdata = 32'h00E0_0000; bus_we = 1'b1; ev_dma_err = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; ev_dma_err = 1'b0;
        rd(A_ST, v); chk("R4 set wins", v, 32'h0040_0000);
        wr(A_ST, 32'hFFFF_FFFF);

        // R11: writing ones to clear bits does not set them
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); chk("R11 status not set", v, 32'h0);
        wr(A_TRD, 32'hFFFF_FFFF);
        rd(A_TRD, v); chk("R11 trd not set", v, 32'h0);

        // R7: latch while disabled, enable later
        pulse(3'b100, '0);
        chk("R7 irq off while disabled", {31'b0, irq_o}, 32'h0);
        rd(A_ST, v); chk("R7 latched", v, 32'h0080_0000);
        wr(A_EN, 32'h0080_0000);
        chk("R7 no global", {31'b0, irq_o}, 32'h0);
        wr(A_EN, 32'h8080_0000);
        chk("R7 irq after enable", {31'b0, irq_o}, 32'h1);
        wr(A_ST, 32'h0080_0000);
        chk("R7 irq after clear", {31'b0, irq_o}, 32'h0);
        wr(A_EN, 32'h0);

        // R8 R9: every completion bit, unmasked
        for (int i = 0; i < TRD_W; i++) begin
            pulse('0, TRD_W'(1) << i);
            rd(A_TRD, v); chk("R8 trd set", v, 32'(1) << i);
            chk("R9 trd irq", {31'b0, irq_o}, 32'h1);
            wr(A_TRD, 32'(1) << i);
            rd(A_TRD, v); chk("R8 trd clear", v, 32'h0);
            chk("R9 irq drops", {31'b0, irq_o}, 32'h0);
        end
        pulse('0, 8'hA5);
        wr(A_TRD, 32'h0000_0005);
        rd(A_TRD, v); chk("R8 partial trd clear", v, 32'h0000_00A0);
        chk("R9 irq partial", {31'b0, irq_o}, 32'h1);
        wr(A_TRD, 32'h0000_00FF);

        // R10: unmapped offsets
        wr(A_EN, 32'h8060_0000);
        pulse(3'b010, '0);
        wr(12'h118, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h118, v); chk("R10 read unmapped 118", v, 32'h0);
        rd(12'h124, v); chk("R10 read unmapped 124", v, 32'h0);
        rd(A_EN, v);    chk("R10 enable untouched", v, 32'h8060_0000);
        rd(A_ST, v);    chk("R10 status untouched", v, 32'h0040_0000);
        chk("R10 irq held", {31'b0, irq_o}, 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule